// File: doc/BRIEF.md
# Two-Channel Offset/Gain Trim and Self-Calibration Engine

This block takes a stream of already-filtered conversion results, each tagged with one of two channel numbers, and trims every result with that channel's own correction pair. It first adds the channel's signed offset word. It then multiplies by the channel's unsigned gain word. The trimmed result is returned one cycle later as a 24-bit two's complement fraction that saturates at the ends of the range [-1, +1).

The same engine can also learn the correction words. A calibration command picks one kind of calibration and a set of channels. The engine then gathers the next N raw results of each chosen channel, where N is the cycle-count input. When it has them, a single shared serial divider turns each channel's sum into a new register value. In offset calibration the new offset is the negated mean. In gain calibration the new gain is the ratio of a full-scale target to the mean, limited to a ceiling just under 4.0. When the engine has finished it raises a completion flag. No trimmed results are produced while a calibration is in progress.

Top module: `ogc_engine`

## Requirements
- R1: Reset sets every offset to 0 and every gain to 0x400000 (1.0 in unsigned fixed point with 2 integer and 22 fraction bits). Reset also clears the invalid-gain flags, `cal_busy_o`, `cal_done_o` and `out_valid_o`.
- R2: Take a sample that is presented while `cal_busy_o` is low. On the next clock edge `out_valid_o` rises, `out_chan_o` repeats the channel, and `out_data_o` = floor((x + offset[c]) * gain[c] / 2^22).
- R3: If the trimmed result falls outside the 24-bit signed range, it is clamped to 0x7FFFFF or to 0x800000.
- R4: While `cal_busy_o` is high, no sample produces an output.
- R5: A command is accepted only when the engine is idle, exactly one bit of `cmd_kind_i` is set (bit 0 = offset calibration, bit 1 = gain calibration), `cmd_mask_i` is non-zero (bit c selects channel c) and N ≥ 1. Any other command changes nothing.
- R6: A command with both kind bits set is ignored: busy stays low, `cal_done_o` keeps its value, and all registers stay unchanged.
- R7: For each selected channel, the calibration sum S is taken over that channel's first N raw samples after the command is accepted. Later samples of a channel that already has N samples are left out, and so are the samples of unselected channels.
- R8: Offset calibration writes -trunc(S/N), where the division truncates toward zero. A result of +2^23 is clamped to 0x7FFFFF.
- R9: Gain calibration computes q = floor((2^23-1)·2^22·N / S). If S ≤ 0 or q ≥ 2^24, the channel's invalid-gain flag is set and its gain is kept. Otherwise the gain becomes q and the flag is cleared.
- R10: A calibration changes only the selected channels, and only the register of its own kind. Outside a calibration, no register changes.
- R11: `cal_busy_o` rises on the edge that accepts a command and falls when the last selected channel has been written. `cal_done_o` rises on that same edge and stays high until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 1 | Sample channel number |
| smp_data_i | input | 24 | Filtered sample, two's complement |
| cmd_valid_i | input | 1 | Calibration command strobe |
| cmd_kind_i | input | 2 | bit 0 offset cal, bit 1 gain cal |
| cmd_mask_i | input | 2 | Channel select mask |
| cycles_n_i | input | 12 | Samples per channel to average (N) |
| out_valid_o | output | 1 | Trimmed sample strobe |
| out_chan_o | output | 1 | Trimmed sample channel |
| out_data_o | output | 24 | Trimmed sample, saturated |
| ofs_o | output | 48 | Offset words, channel c at bits [24c+23:24c] |
| gain_o | output | 48 | Gain words, channel c at bits [24c+23:24c] |
| gain_bad_o | output | 2 | Invalid-gain flag per channel |
| cal_busy_o | output | 1 | Calibration in progress |
| cal_done_o | output | 1 | Calibration completed |

## Verification
The outcomes that are hardest to reach are the calibration corners. These are a mean of exactly -2^23, whose negation does not fit; a gain quotient that needs more than 24 bits; a non-positive sum; and a two-channel run in which one channel has its N samples long before the other. The stimulus reaches each of them with constant sample sequences chosen so that every outcome is known exactly. It also feeds extra samples of an already-full channel in the middle of a run. Each calibration is followed by trimmed samples that exercise the new words near both saturation limits.

// File: rtl/ogc_pkg.sv
package ogc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_PICK = 2'd2,
    ST_WAIT = 2'd3
  } cal_st_e;
endpackage

// File: rtl/ogc_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
module ogc_divider #(
  parameter int DVD_W = 57,
  parameter int DVS_W = 36,
  localparam int CW   = $clog2(DVD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  logic             run_q, run_d, done_q, done_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DVS_W:0]   rem_q, rem_d, rem_sh;
  logic [DVD_W-1:0] quo_q, quo_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic             fits;

  assign rem_sh = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
  assign fits   = rem_sh >= {1'b0, dvs_q};

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    done_d = 1'b0;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = '0;
      rem_d = '0;
      quo_d = dvd_i;
      dvs_d = dvs_i;
    end else if (run_q) begin
      rem_d = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
      quo_d = {quo_q[DVD_W-2:0], fits};
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(DVD_W - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/ogc_accum.sv
// Per-channel sample summer that stops after n_i samples.
module ogc_accum #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12,
  parameter int SUM_W  = DATA_W + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [CNT_W-1:0]        n_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic                    full_o
);
  logic signed [SUM_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    upd_en;

  assign full_o = (cnt_q == n_i);
  assign upd_en = clr_i | (en_i & ~full_o);

  always_comb begin
    if (clr_i) begin
      sum_d = '0;
      cnt_d = '0;
    end else begin
      sum_d = sum_q + SUM_W'($signed(data_i));
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/ogc_corrector.sv
// Offset add, gain multiply, floor shift, saturate; one register stage.
module ogc_corrector #(
  parameter int DATA_W    = 24,
  parameter int GAIN_FRAC = 22,
  parameter int CH_W      = 1,
  localparam int PW       = 2 * DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ofs_i,
  input  logic [DATA_W-1:0] gain_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic signed [PW-1:0] SMAX = $signed((PW'(1) << (DATA_W - 1)) - PW'(1));
  localparam logic signed [PW-1:0] SMIN = -SMAX - PW'(1);

  logic signed [DATA_W:0] sum;
  logic signed [PW-1:0]   prod, shf;
  logic [DATA_W-1:0]      res_d;

  always_comb begin
    sum  = $signed({data_i[DATA_W-1], data_i}) + $signed({ofs_i[DATA_W-1], ofs_i});
    prod = sum * $signed({1'b0, gain_i});
    shf  = prod >>> GAIN_FRAC;
    if (shf > SMAX)      res_d = SMAX[DATA_W-1:0];
    else if (shf < SMIN) res_d = SMIN[DATA_W-1:0];
    else                 res_d = shf[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_o <= '0;
      data_o <= '0;
    end else if (valid_i) begin
      chan_o <= chan_i;
      data_o <= res_d;
    end
  end
endmodule

// File: rtl/ogc_engine.sv
module ogc_engine #(
  parameter int NCH       = 2,
  parameter int DATA_W    = 24,
  parameter int GAIN_FRAC = 22,
  parameter int CNT_W     = 12,
  localparam int CH_W     = $clog2(NCH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_valid_i,
  input  logic [CH_W-1:0]              smp_chan_i,
  input  logic [DATA_W-1:0]            smp_data_i,
  input  logic                         cmd_valid_i,
  input  logic [1:0]                   cmd_kind_i,
  input  logic [NCH-1:0]               cmd_mask_i,
  input  logic [CNT_W-1:0]             cycles_n_i,
  output logic                         out_valid_o,
  output logic [CH_W-1:0]              out_chan_o,
  output logic [DATA_W-1:0]            out_data_o,
  output logic [NCH-1:0][DATA_W-1:0]   ofs_o,
  output logic [NCH-1:0][DATA_W-1:0]   gain_o,
  output logic [NCH-1:0]               gain_bad_o,
  output logic                         cal_busy_o,
  output logic                         cal_done_o
);
  import ogc_pkg::*;

  localparam int SUM_W = DATA_W + CNT_W;
  localparam int TGT_W = DATA_W - 1 + GAIN_FRAC;
  localparam int DVD_W = TGT_W + CNT_W;
  localparam int DVS_W = SUM_W;
  localparam logic [DVD_W-1:0]  TARGET   = (DVD_W'(1) << TGT_W) - (DVD_W'(1) << GAIN_FRAC);
  localparam logic [DATA_W-1:0] POS_MAX  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(1) << GAIN_FRAC;

  // reset: asserted asynchronously, released on the clock
  logic rs_q1, rs_q2, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign srst_n = rs_q2;

  cal_st_e                    state_q, state_d;
  logic                       gmode_q, gmode_d;
  logic [NCH-1:0]             mask_q, mask_d, left_q, left_d, left_nx;
  logic [CNT_W-1:0]           n_q, n_d;
  logic [CH_W-1:0]            sel_q, sel_d, pick;
  logic [NCH-1:0][DATA_W-1:0] ofs_q, ofs_d, gain_q, gain_d;
  logic [NCH-1:0]             bad_q, bad_d;
  logic                       done_q, done_d;

  logic                       acc_clr, div_start, div_done, cmd_ok;
  logic [NCH-1:0]             acc_en, acc_full;
  logic signed [SUM_W-1:0]    acc_sum [NCH];
  logic [DVD_W-1:0]           div_dvd, div_quot;
  logic [DVS_W-1:0]           div_dvs;
  logic signed [SUM_W-1:0]    cur;
  logic [SUM_W-1:0]           cur_mag;

  assign cmd_ok = cmd_valid_i && (cmd_kind_i[0] ^ cmd_kind_i[1]) &&
                  (|cmd_mask_i) && (|cycles_n_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign acc_en[c] = (state_q == ST_ACC) && smp_valid_i &&
                       (smp_chan_i == CH_W'(c)) && mask_q[c];
    ogc_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(srst_n), .clr_i(acc_clr), .en_i(acc_en[c]),
      .data_i(smp_data_i), .n_i(n_q), .sum_o(acc_sum[c]), .full_o(acc_full[c])
    );
  end

  ogc_divider #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk(clk), .rst_n(srst_n), .start_i(div_start), .dvd_i(div_dvd),
    .dvs_i(div_dvs), .done_o(div_done), .quot_o(div_quot)
  );

  always_comb begin
    state_d   = state_q;
    gmode_d   = gmode_q;
    mask_d    = mask_q;
    n_d       = n_q;
    sel_d     = sel_q;
    left_d    = left_q;
    left_nx   = left_q;
    ofs_d     = ofs_q;
    gain_d    = gain_q;
    bad_d     = bad_q;
    done_d    = done_q;
    acc_clr   = 1'b0;
    div_start = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    pick      = sel_q;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (left_q[i]) pick = CH_W'(i);
    end
    cur     = (state_q == ST_PICK) ? acc_sum[pick] : acc_sum[sel_q];
    cur_mag = cur[SUM_W-1] ? (SUM_W'(0) - cur) : cur;
    case (state_q)
      ST_IDLE: begin
        if (cmd_ok) begin
          state_d = ST_ACC;
          gmode_d = cmd_kind_i[1];
          mask_d  = cmd_mask_i;
          n_d     = cycles_n_i;
          acc_clr = 1'b1;
          done_d  = 1'b0;
        end
      end
      ST_ACC: begin
        if (&(acc_full | ~mask_q)) begin
          left_d  = mask_q;
          state_d = ST_PICK;
        end
      end
      ST_PICK: begin
        sel_d = pick;
        if (gmode_q && (cur[SUM_W-1] || cur == '0)) begin
          bad_d[pick]   = 1'b1;
          left_nx[pick] = 1'b0;
          left_d        = left_nx;
          if (left_nx == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          div_start = 1'b1;
          state_d   = ST_WAIT;
          if (gmode_q) begin
            div_dvd = TARGET * DVD_W'(n_q);
            div_dvs = DVS_W'(cur);
          end else begin
            div_dvd = DVD_W'(cur_mag);
            div_dvs = DVS_W'(n_q);
          end
        end
      end
      ST_WAIT: begin
        if (div_done) begin
          if (gmode_q) begin
            if (|div_quot[DVD_W-1:DATA_W]) begin
              bad_d[sel_q] = 1'b1;
            end else begin
              gain_d[sel_q] = div_quot[DATA_W-1:0];
              bad_d[sel_q]  = 1'b0;
            end
          end else if (cur[SUM_W-1]) begin
            ofs_d[sel_q] = (div_quot > DVD_W'(POS_MAX)) ? POS_MAX : div_quot[DATA_W-1:0];
          end else begin
            ofs_d[sel_q] = DATA_W'(0) - div_quot[DATA_W-1:0];
          end
          left_nx[sel_q] = 1'b0;
          left_d         = left_nx;
          if (left_nx == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_PICK;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      gmode_q <= 1'b0;
      mask_q  <= '0;
      n_q     <= '0;
      sel_q   <= '0;
      left_q  <= '0;
      ofs_q   <= '0;
      gain_q  <= {NCH{GAIN_ONE}};
      bad_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gmode_q <= gmode_d;
      mask_q  <= mask_d;
      n_q     <= n_d;
      sel_q   <= sel_d;
      left_q  <= left_d;
      ofs_q   <= ofs_d;
      gain_q  <= gain_d;
      bad_q   <= bad_d;
      done_q  <= done_d;
    end
  end

  ogc_corrector #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC), .CH_W(CH_W)) u_corr (
    .clk(clk), .rst_n(srst_n),
    .valid_i(smp_valid_i && (state_q == ST_IDLE)),
    .chan_i(smp_chan_i), .data_i(smp_data_i),
    .ofs_i(ofs_q[smp_chan_i]), .gain_i(gain_q[smp_chan_i]),
    .valid_o(out_valid_o), .chan_o(out_chan_o), .data_o(out_data_o)
  );

  assign ofs_o      = ofs_q;
  assign gain_o     = gain_q;
  assign gain_bad_o = bad_q;
  assign cal_busy_o = (state_q != ST_IDLE);
  assign cal_done_o = done_q;
endmodule

// File: rtl/ogc_engine_chk.sv
module ogc_engine_chk #(
  parameter int NCH    = 2,
  parameter int DATA_W = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       smp_valid_i,
  input logic                       cmd_valid_i,
  input logic [1:0]                 cmd_kind_i,
  input logic                       out_valid_o,
  input logic [NCH-1:0][DATA_W-1:0] ofs_o,
  input logic [NCH-1:0][DATA_W-1:0] gain_o,
  input logic [NCH-1:0]             gain_bad_o,
  input logic                       cal_busy_o,
  input logic                       cal_done_o
);
  // R2 and R4: an output only follows a sample taken while idle
  assert_out_follows_idle_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ($past(smp_valid_i) && !$past(cal_busy_o)));

  assert_regs_frozen_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cal_busy_o) |-> ($stable(ofs_o) && $stable(gain_o) && $stable(gain_bad_o)));

  assert_done_with_finish_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done_o) |-> $fell(cal_busy_o));

  assert_combined_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_kind_i == 2'b11 && !cal_busy_o) |=> !cal_busy_o);

  assert_badflag_from_cal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_bad_o) |-> $past(cal_busy_o));
endmodule

bind ogc_engine ogc_engine_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .cmd_valid_i(cmd_valid_i),
  .cmd_kind_i(cmd_kind_i), .out_valid_o(out_valid_o), .ofs_o(ofs_o),
  .gain_o(gain_o), .gain_bad_o(gain_bad_o), .cal_busy_o(cal_busy_o),
  .cal_done_o(cal_done_o)
);

// File: tb/tb_ogc_engine.sv
module tb_ogc_engine;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [0:0]  smp_chan;
  logic [23:0] smp_data;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [1:0]  cmd_mask;
  logic [11:0] cyc_n;
  logic        out_valid;
  logic [0:0]  out_chan;
  logic [23:0] out_data;
  logic [1:0][23:0] ofs_o, gain_o;
  logic [1:0]  gain_bad;
  logic        cal_busy, cal_done;

  ogc_engine dut (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_chan_i(smp_chan),
    .smp_data_i(smp_data), .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
    .cmd_mask_i(cmd_mask), .cycles_n_i(cyc_n), .out_valid_o(out_valid),
    .out_chan_o(out_chan), .out_data_o(out_data), .ofs_o(ofs_o), .gain_o(gain_o),
    .gain_bad_o(gain_bad), .cal_busy_o(cal_busy), .cal_done_o(cal_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint m_ofs[2];
  longint m_gain[2];
  longint m_bad[2];
  logic   busy_s = 1'b0;
  logic   chk_on = 1'b0;
  logic   exp_v  = 1'b0;
  longint exp_c  = 0;
  longint exp_d  = 0;

  function automatic void chk(string tag, longint got, longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endfunction

  function automatic longint trim(int c, longint x);
    longint p;
    p = ((x + m_ofs[c]) * m_gain[c]) >>> 22;
    if (p > 8388607)  p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  function automatic longint neg_mean(longint s, longint n);
    longint r;
    r = -(s / n);
    if (r > 8388607) r = 8388607;
    return r;
  endfunction

  function automatic void apply_gain(int c, longint s, longint n);
    longint q;
    if (s <= 0) m_bad[c] = 1;
    else begin
      q = (longint'(8388607) * 4194304 * n) / s;
      if (q >= 16777216) m_bad[c] = 1;
      else begin
        m_gain[c] = q;
        m_bad[c]  = 0;
      end
    end
  endfunction

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ofs[c] = 0; m_gain[c] = 4194304; m_bad[c] = 0;
    end
  endfunction

  // behavioural reference for the trimmed stream
  always @(posedge clk) begin
    if (!rst_n) exp_v <= 1'b0;
    else begin
      exp_v <= smp_valid && !busy_s;
      exp_c <= longint'(smp_chan);
      exp_d <= trim(int'(smp_chan), longint'($signed(smp_data)));
    end
  end

  always @(negedge clk) begin
    busy_s <= cal_busy;
    if (rst_n && chk_on) begin
      chk("R4 out_valid vs model", longint'(out_valid), longint'(exp_v));
      if (exp_v) begin
        chk("R2 out_chan", longint'(out_chan), exp_c);
        chk("R2/R3 out_data", longint'($signed(out_data)), exp_d);
      end
    end
  end

  function automatic void chk_regs(string tag);
    for (int c = 0; c < 2; c++) begin
      chk({tag, " offset"}, longint'($signed(ofs_o[c])), m_ofs[c]);
      chk({tag, " gain"}, longint'(gain_o[c]), m_gain[c]);
      chk({tag, " bad flag"}, longint'(gain_bad[c]), m_bad[c]);
    end
  endfunction

  task automatic smp(int c, longint v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_chan  = 1'(c);
    smp_data  = 24'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic cmd(int kind, int mask, int n);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_kind  = 2'(kind);
    cmd_mask  = 2'(mask);
    cyc_n     = 12'(n);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!cal_done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk("R11 calibration finished", longint'(cal_done), 1);
    chk("R11 busy low after finish", longint'(cal_busy), 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
    cmd_valid = 1'b0; cmd_kind = '0; cmd_mask = '0; cyc_n = '0;
    model_reset();
    repeat (4) @(negedge clk);
    chk("R1 out_valid in reset", longint'(out_valid), 0);
    chk("R1 busy in reset", longint'(cal_busy), 0);
    chk("R1 done in reset", longint'(cal_done), 0);
    chk_regs("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;

    // R2 default pass-through
    smp(0, 123456); smp(1, -8388608); smp(0, 8388607); smp(1, -1);

    // R8 offset calibration on channel 0 with an unselected channel interleaved
    cmd(1, 1, 4);
    chk("R11 busy after accept", longint'(cal_busy), 1);
    chk("R11 done cleared on accept", longint'(cal_done), 0);
    smp(0, 100); smp(1, 555); smp(0, 102); smp(0, 98); smp(0, 101);
    wait_done();
    m_ofs[0] = neg_mean(401, 4);
    chk_regs("R8/R10 offset cal ch0");
    smp(0, 500); smp(1, 500);

    // R9 gain calibration on channel 1
    cmd(2, 2, 4);
    repeat (4) smp(1, 4194304);
    wait_done();
    apply_gain(1, 16777216, 4);
    chk_regs("R9 gain cal ch1");
    // R3 saturation both ways and floor rounding
    smp(1, 4194304); smp(1, 6291456); smp(1, -8388608); smp(1, -1000); smp(0, -8388608);

    // R9 gain above ceiling -> invalid, gain kept
    cmd(2, 1, 2);
    smp(0, 1000); smp(0, 1000);
    wait_done();
    apply_gain(0, 2000, 2);
    chk_regs("R9 gain overflow");
    // R9 non-positive sum -> invalid
    cmd(2, 1, 2);
    smp(0, -5); smp(0, -5);
    wait_done();
    apply_gain(0, -10, 2);
    chk_regs("R9 negative sum");
    // R9 valid result clears the flag
    cmd(2, 1, 2);
    smp(0, 8388607); smp(0, 8388607);
    wait_done();
    apply_gain(0, 16777214, 2);
    chk_regs("R9 flag cleared");

    // R7 both channels, extra sample of a full channel left out, truncation
    cmd(1, 3, 2);
    smp(0, 7); smp(0, -2); smp(0, 1000); smp(1, -7); smp(1, -2);
    wait_done();
    m_ofs[0] = neg_mean(5, 2);
    m_ofs[1] = neg_mean(-9, 2);
    chk_regs("R7/R8/R10 dual offset cal");
    smp(0, 10); smp(1, 10);

    // R8 clamp of negated minimum mean
    cmd(1, 2, 3);
    repeat (3) smp(1, -8388608);
    wait_done();
    m_ofs[1] = neg_mean(-25165824, 3);
    chk_regs("R8 offset clamp");

    // R6 combined request ignored
    cmd(3, 3, 4);
    chk("R6 busy stays low", longint'(cal_busy), 0);
    chk("R6 done kept", longint'(cal_done), 1);
    smp(0, 77);
    chk_regs("R6 registers kept");

    // R5 other rejected commands
    cmd(1, 1, 0);
    chk("R5 N=0 ignored", longint'(cal_busy), 0);
    cmd(1, 0, 4);
    chk("R5 empty mask ignored", longint'(cal_busy), 0);
    cmd(0, 1, 4);
    chk("R5 no kind ignored", longint'(cal_busy), 0);
    chk("R5 done kept", longint'(cal_done), 1);
    smp(1, 20);
    chk_regs("R5 registers kept");

    // R1 reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk_regs("R1 second reset");
    chk("R1 done after reset", longint'(cal_done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    smp(0, 42); smp(1, -42);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule